// File: doc/BRIEF.md
# Voice Envelope Generator with Equality-Matched Rate Timer

This block shapes the loudness of one voice of a retro sound synthesizer. A single write strobe loads a gate bit and four 4-bit fields: three step rates, for the rise, the fall and the fade, and one hold level. From these the block produces an 8-bit envelope level that a downstream multiplier can apply to the waveform. Setting the gate starts a linear rise. When the level tops out, the block falls towards the hold level. Clearing the gate fades the level to silence.

The timing base is a free-running 15-bit counter. Each cycle it is compared for equality with a period chosen by the rate field of the active phase. On a match the counter restarts and the envelope is allowed one step. The fall and the fade also pass through a divider whose ratio grows as the level drops, which gives a curve that approximates an exponential. Because the comparison is for equality only, a write that picks a shorter period than the count already reached makes the counter run all the way round its 15-bit range before the next step. Software must plan around this stall, and the block keeps it on purpose. The change from rise to fall is made inside the block and never stalls.

Top module: `env_gen`

## Requirements
- R1: The rate counter advances by one every clock and restarts from zero on the cycle it equals the selected period minus one. While the phase and its rate field stay unchanged, envelope steps in the rise phase are exactly one period apart.
- R2: The period in clock cycles for each rate code is: code 0 gives 9, code 1 gives 32, code 2 gives 63, code 8 gives 392, code 9 gives 977 and code 14 gives 19532. The other codes follow the same increasing table.
- R3: A write that moves the gate bit from 0 to 1 enters the rise phase. Each step in the rise phase adds one to the level, starting from the level present at the time of the write and not from zero.
- R4: When a rise step brings the level to 0xFF, the phase changes to fall on that same edge. The first fall step follows exactly one fall period later, with no stall.
- R5: In the fall phase the level stops and holds once it equals the hold field copied into both nibbles (hold 0xA gives 0xAA).
- R6: A write that moves the gate bit from 1 to 0 enters the fade phase. Each fade step subtracts one, and the level stays at 0x00 once it gets there.
- R7: Fall and fade steps occur once every N rate matches, where N depends on the level that is about to be left: N=1 above 0x5D, 2 for 0x37 to 0x5D, 4 for 0x1B to 0x36, 8 for 0x0F to 0x1A, 16 for 0x07 to 0x0E and 30 for 0x00 to 0x06. Rise steps ignore N.
- R8: If a write selects a period whose compare value is below the current count, the counter wraps through its 15-bit range before it next matches. The next step then arrives close to 32768 cycles later, minus the count already reached.
- R9: If a write selects a period whose compare value is at or above the current count, the next step arrives within one new period. This covers every change from a faster rate to a slower one.
- R10: After reset the level is 0x00, the phase is fade and the counter is zero. The level stays at 0x00 until the gate is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe that loads all of the fields below |
| wr_gate | input | 1 | Gate bit: 1 starts or keeps the note, 0 releases it |
| wr_rise | input | 4 | Rate code for the rise phase |
| wr_fall | input | 4 | Rate code for the fall phase |
| wr_hold | input | 4 | Hold level nibble for the fall phase |
| wr_fade | input | 4 | Rate code for the fade phase |
| env_o | output | 8 | Envelope level |

## Verification
Some rules are checked by assertions on every cycle. These are the restart and the single-step advance of the rate counter, its wrap from all-ones to zero, the one-up rise step, the same-edge change from rise to fall at the top, the hold at the sustain byte, the floor at zero during fade, and the bound on the divider count. Other behaviour only shows up across many cycles, so the bench scenarios must demonstrate it. This includes the exact period per rate code and the interval per divider band. It also includes the difference in delay between a write that lowers the period below the running count, which stalls for about 32768 cycles, and one that does not, which responds within a period.

// File: rtl/env_pkg.sv
package env_pkg;

   typedef enum logic [1:0] {
      PH_RISE = 2'd0,
      PH_FALL = 2'd1,
      PH_FADE = 2'd2
   } env_phase_e;

   localparam int RATE_CODE_W = 4;
   localparam int PERIOD_W    = 15;
   localparam int RATIO_W     = 5;

   // Clock cycles between rate matches for each 4-bit rate code.
   function automatic logic [PERIOD_W-1:0] rate_period(input logic [RATE_CODE_W-1:0] code);
      logic [PERIOD_W-1:0] p;
      case (code)
         4'd0:    p = 15'd9;
         4'd1:    p = 15'd32;
         4'd2:    p = 15'd63;
         4'd3:    p = 15'd95;
         4'd4:    p = 15'd149;
         4'd5:    p = 15'd220;
         4'd6:    p = 15'd267;
         4'd7:    p = 15'd313;
         4'd8:    p = 15'd392;
         4'd9:    p = 15'd977;
         4'd10:   p = 15'd1954;
         4'd11:   p = 15'd3126;
         4'd12:   p = 15'd3907;
         4'd13:   p = 15'd11720;
         4'd14:   p = 15'd19532;
         default: p = 15'd31251;
      endcase
      return p;
   endfunction

   // Rate matches per fall/fade step, chosen by the level about to be left.
   function automatic logic [RATIO_W-1:0] exp_ratio(input logic [7:0] lvl);
      logic [RATIO_W-1:0] r;
      if (lvl > 8'h5D)       r = 5'd1;
      else if (lvl >= 8'h37) r = 5'd2;
      else if (lvl >= 8'h1B) r = 5'd4;
      else if (lvl >= 8'h0F) r = 5'd8;
      else if (lvl >= 8'h07) r = 5'd16;
      else                   r = 5'd30;
      return r;
   endfunction

endpackage

// File: rtl/env_rate_timer.sv
module env_rate_timer #(
   parameter int CNT_W  = 15,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);
   import env_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] match_val;

   initial begin
      assert (CNT_W >= PERIOD_W) else $error("rate counter narrower than period table");
      assert (CODE_W == RATE_CODE_W) else $error("rate code width mismatch");
   end

   // Compare value is the period minus one, so matches are a full period apart.
   assign match_val = CNT_W'(rate_period(code_i)) - CNT_ONE;
   assign tick_o    = (cnt_q == match_val);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_ONE;
   end

   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0));

   p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_o && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_o && cnt_q == CNT_MAX) |=> (cnt_q == '0));

endmodule

// File: rtl/env_exp_divider.sv
module env_exp_divider #(
   parameter int LVL_W  = 8,
   parameter int DIV_W  = 5,
   parameter bit EXP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             linear_i,
   input  logic [LVL_W-1:0] level_i,
   output logic             step_o
);
   import env_pkg::*;

   initial begin
      assert (LVL_W == 8) else $error("divider bands assume an 8-bit level");
      assert (DIV_W >= RATIO_W) else $error("divider count too narrow");
   end

   generate
      if (EXP_EN) begin : g_exp
         logic [DIV_W-1:0] ecnt_q;
         logic [DIV_W-1:0] last_val;
         logic             wrap;

         assign last_val = DIV_W'(exp_ratio(level_i)) - DIV_W'(1);
         assign wrap     = linear_i || (ecnt_q >= last_val);
         assign step_o   = tick_i && wrap;

         always_ff @(posedge clk) begin
            if (!rst_n)      ecnt_q <= '0;
            else if (tick_i) ecnt_q <= wrap ? '0 : ecnt_q + DIV_W'(1);
         end

         p_div_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ecnt_q < DIV_W'(30));

         p_div_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i |=> $stable(ecnt_q));
      end else begin : g_lin
         logic unused_ok;
         assign unused_ok = linear_i ^ (^level_i) ^ clk ^ rst_n;
         assign step_o    = tick_i;
      end
   endgenerate

endmodule

// File: rtl/env_level_fsm.sv
module env_level_fsm #(
   parameter int LVL_W  = 8,
   parameter int CODE_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  gate_set_i,
   input  logic                  gate_clr_i,
   input  logic                  step_i,
   input  logic [CODE_W-1:0]     hold_i,
   output env_pkg::env_phase_e   phase_o,
   output logic [LVL_W-1:0]      level_o
);
   import env_pkg::*;

   localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
   localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
   localparam int               REP     = LVL_W / CODE_W;

   env_phase_e       phase_q;
   logic [LVL_W-1:0] level_q;
   logic [LVL_W-1:0] hold_byte;

   initial assert (LVL_W == REP * CODE_W) else $error("level width must be a multiple of the nibble");

   assign hold_byte = {REP{hold_i}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FADE;
         level_q <= '0;
      end else if (gate_set_i) begin
         phase_q <= PH_RISE;
      end else if (gate_clr_i) begin
         phase_q <= PH_FADE;
      end else if (step_i) begin
         case (phase_q)
            PH_RISE: begin
               if (level_q == LVL_MAX) begin
                  phase_q <= PH_FALL;
               end else begin
                  level_q <= level_q + LVL_ONE;
                  if (level_q == LVL_MAX - LVL_ONE) phase_q <= PH_FALL;
               end
            end
            PH_FALL: if (level_q > hold_byte) level_q <= level_q - LVL_ONE;
            default: if (level_q != '0)       level_q <= level_q - LVL_ONE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign level_o = level_q;

   p_gate_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gate_set_i |=> (phase_q == PH_RISE));

   p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RISE && step_i && !gate_set_i && !gate_clr_i && level_q != LVL_MAX)
      |=> (level_q == $past(level_q) + LVL_ONE));

   p_top_to_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RISE && step_i && !gate_set_i && !gate_clr_i && level_q == LVL_MAX - LVL_ONE)
      |=> (phase_q == PH_FALL && level_q == LVL_MAX));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FALL && level_q == hold_byte && !gate_set_i && !gate_clr_i)
      |=> $stable(level_q));

   p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FADE && level_q == '0 && !gate_set_i) |=> (level_q == '0));

   p_clear_fade_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_clr_i && !gate_set_i) |=> (phase_q == PH_FADE));

endmodule

// File: rtl/env_gen.sv
module env_gen #(
   parameter int LVL_W  = 8,
   parameter int CODE_W = 4,
   parameter int CNT_W  = 15,
   parameter int DIV_W  = 5,
   parameter bit EXP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_gate,
   input  logic [CODE_W-1:0] wr_rise,
   input  logic [CODE_W-1:0] wr_fall,
   input  logic [CODE_W-1:0] wr_hold,
   input  logic [CODE_W-1:0] wr_fade,
   output logic [LVL_W-1:0]  env_o
);
   import env_pkg::*;

   logic              gate_q;
   logic [CODE_W-1:0] rise_q, fall_q, hold_q, fade_q;
   logic              gate_set, gate_clr;
   logic [CODE_W-1:0] code_sel;
   logic              tick, step;
   env_phase_e        phase;
   logic [LVL_W-1:0]  level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         rise_q <= '0;
         fall_q <= '0;
         hold_q <= '0;
         fade_q <= '0;
      end else if (wr_en) begin
         gate_q <= wr_gate;
         rise_q <= wr_rise;
         fall_q <= wr_fall;
         hold_q <= wr_hold;
         fade_q <= wr_fade;
      end
   end

   assign gate_set = wr_en &&  wr_gate && !gate_q;
   assign gate_clr = wr_en && !wr_gate &&  gate_q;

   always_comb begin
      case (phase)
         PH_RISE: code_sel = rise_q;
         PH_FALL: code_sel = fall_q;
         default: code_sel = fade_q;
      endcase
   end

   env_rate_timer #(.CNT_W(CNT_W), .CODE_W(CODE_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (code_sel),
      .tick_o (tick)
   );

   env_exp_divider #(.LVL_W(LVL_W), .DIV_W(DIV_W), .EXP_EN(EXP_EN)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .linear_i (phase == PH_RISE),
      .level_i  (level),
      .step_o   (step)
   );

   env_level_fsm #(.LVL_W(LVL_W), .CODE_W(CODE_W)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_set_i (gate_set),
      .gate_clr_i (gate_clr),
      .step_i     (step),
      .hold_i     (hold_q),
      .phase_o    (phase),
      .level_o    (level)
   );

   assign env_o = level;

   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_q && !wr_en && level == '0) |=> (level == '0));

endmodule

// File: tb/env_gen_tb_top.sv
module env_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic       wr_gate;
   logic [3:0] wr_rise, wr_fall, wr_hold, wr_fade;
   logic [7:0] env_o;

   int n_run  = 0;
   int n_fail = 0;

   always #5ns clk = ~clk;  // 100 MHz

   env_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_gate(wr_gate),
      .wr_rise(wr_rise), .wr_fall(wr_fall), .wr_hold(wr_hold), .wr_fade(wr_fade),
      .env_o(env_o)
   );

   // {rate code, expected period in cycles}
   localparam logic [19:0] VEC [0:4] = '{
      {4'd0, 16'd9}, {4'd1, 16'd32}, {4'd2, 16'd63}, {4'd8, 16'd392}, {4'd9, 16'd977}
   };

   function automatic int ratio_ref(input logic [7:0] l);
      if (l >= 8'h5E) return 1;
      if (l >= 8'h37) return 2;
      if (l >= 8'h1B) return 4;
      if (l >= 8'h0F) return 8;
      if (l >= 8'h07) return 16;
      return 30;
   endfunction

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; wr_gate = 1'b0;
      wr_rise = '0; wr_fall = '0; wr_hold = '0; wr_fade = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write(input bit g, input logic [3:0] r, input logic [3:0] f,
                        input logic [3:0] h, input logic [3:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_gate = g; wr_rise = r; wr_fall = f; wr_hold = h; wr_fade = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Cycles until env_o changes, and the new value.
   task automatic wait_change(output int n, output logic [7:0] v);
      logic [7:0] prev;
      prev = env_o;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (env_o == prev && n < 40000);
      v = env_o;
   endtask

   task automatic wait_level(input logic [7:0] target);
      int n;
      n = 0;
      while (env_o != target && n < 40000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      #2_000_000ns;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n;
      logic [7:0] v, prev;

      // R10: reset state and quiet idle
      do_reset();
      check("R10 reset level", env_o == 8'h00, env_o, 0);
      repeat (500) @(negedge clk);
      check("R10 idle level", env_o == 8'h00, env_o, 0);

      // R1/R2: rise intervals per rate code from the vector table
      for (int i = 0; i < 5; i++) begin
         do_reset();
         write(1'b1, VEC[i][19:16], 4'd0, 4'd0, 4'd0);
         wait_change(n, v);
         wait_change(n, v);
         check("R2 period", n == int'(VEC[i][15:0]), n, int'(VEC[i][15:0]));
         wait_change(n, v);
         check("R1 step spacing", n == int'(VEC[i][15:0]) && v == 8'h03, n, int'(VEC[i][15:0]));
      end

      // R4: top of rise, no stall into fall; R5 hold at 0xAA
      do_reset();
      write(1'b1, 4'd0, 4'd0, 4'hA, 4'd0);
      wait_level(8'hFE);
      wait_change(n, v);
      check("R4 reach top", n == 9 && v == 8'hFF, n, 9);
      wait_change(n, v);
      check("R4 first fall step", n == 9 && v == 8'hFE, n, 9);
      wait_level(8'hAA);
      repeat (2000) @(negedge clk);
      check("R5 hold level", env_o == 8'hAA, env_o, 8'hAA);

      // R7/R6: fade through all divider bands at rate code 0
      write(1'b0, 4'd0, 4'd0, 4'hA, 4'd0);
      wait_change(n, v);
      while (env_o != 8'h00) begin
         prev = env_o;
         wait_change(n, v);
         check("R7 band interval", n == ratio_ref(prev) * 9, n, ratio_ref(prev) * 9);
         check("R6 fade step", v == prev - 8'd1, v, prev - 8'd1);
      end
      repeat (3000) @(negedge clk);
      check("R6 floor at zero", env_o == 8'h00, env_o, 0);

      // R8/R9: stall after slow fade, none for slow-after-fast
      do_reset();
      write(1'b1, 4'd0, 4'd0, 4'hF, 4'd9);
      wait_level(8'hFF);
      repeat (20) @(negedge clk);
      write(1'b0, 4'd0, 4'd0, 4'hF, 4'd9);
      wait_change(n, v);
      check("R9 fast to slow", n >= 960 && n <= 990 && v == 8'hFE, n, 977);
      repeat (500) @(negedge clk);
      write(1'b1, 4'd0, 4'd0, 4'hF, 4'd9);
      wait_change(n, v);
      check("R8 wrap stall", n >= 32000 && n <= 32800, n, 32268);
      check("R3 rise from current level", v == 8'hFF, v, 8'hFF);
      write(1'b0, 4'd0, 4'd0, 4'hF, 4'd9);
      wait_change(n, v);
      write(1'b1, 4'd0, 4'd0, 4'hF, 4'd9);
      wait_change(n, v);
      check("R9 early write no stall", n <= 12 && v == 8'hFF, n, 9);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule